// File: doc/BRIEF.md
# Reconfigurable constant multiplier

This block multiplies a signed input sample by a signed constant. The constant is not stored as a number. It exists only as the contents of small lookup tables, so a new constant, or a new set of table contents, can be shifted in while the chip runs. The input is sign-extended to a whole number of 4-bit slices. Each slice addresses its own 16-entry table of precomputed partial products. The partial products are shifted by their slice weight and summed in a registered binary adder tree.

The tables for all lower slices are loaded from one shared set of serial lines, because they hold the same unsigned products. The table for the most significant slice has its own serial lines, because it holds products in which the slice value is read as a two's-complement number. Computing the table contents is the job of a controller outside this block.

Top module: `reconf_const_mult`

## Requirements
- R1: A synchronous active-high `rst` clears the pipeline and every table to zero. After reset, `product` reads 0 for any input until the tables are loaded again.
- R2: When every lower table holds entry a = a·c and the top table holds entry a = (a<8 ? a : a−16)·c, `product` equals the two's-complement product `data_in`·c in DATA_W+COEF_W bits. A new sample is accepted on every clock. A sample taken at clock edge k appears after edge k+3 (4 register stages at the default sizes).
- R3: The input is sign-extended to 4·K bits, with K = ceil(DATA_W/4). Slice l is bits [4l+3:4l] of the extended value, so the padding bits of the top slice copy the sign bit of `data_in`.
- R4: For any table contents, `product` equals the sum of sext(LO[slice l])·2^(4l) over the lower slices plus sext(HI[top slice])·2^(4(K−1)), modulo 2^(DATA_W+COEF_W). Each entry is a signed value of COEF_W+4 bits.
- R5: All lower tables load from `cfg_lo_din` and always return the same entry for the same address. The top table loads only from `cfg_hi_din`, so its contents may differ from those of the lower tables.
- R6: Each clock with `cfg_en` high shifts one bit into every table cell. Cell j holds entry bits 2j and 2j+1. On shift number t of a 32-shift load, counted from 0, line j carries bit 2j+1 of entry 15−t for t<16 and bit 2j of entry 31−t for t≥16. A load may be split into bursts separated by cycles with `cfg_en` low.
- R7: While `cfg_en` is low, the serial lines are ignored and the table contents do not change.
- R8: The extreme operands are exact: the most negative input and the most positive input, each times the most negative and the most positive coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for all table cells |
| cfg_lo_din | input | ceil((COEF_W+4)/2) | Serial data, one line per cell, shared by the lower-slice tables |
| cfg_hi_din | input | ceil((COEF_W+4)/2) | Serial data, one line per cell, for the top-slice table |
| data_in | input | DATA_W | Signed input sample |
| product | output | DATA_W+COEF_W | Signed product, registered after the last adder |

## Verification
A sample driven before clock edge k passes through the input register, the partial-product register and two adder levels, and it is due on `product` after edge k+3. The bench drives every sample on a falling edge. It compares `product` on the falling edge four cycles later with the value predicted for that sample. It never checks the first four cycles after a table load or a reset, because those outputs still carry older samples.

A table load takes 32 enabled cycles, or more when it is split into bursts. The load is complete before the checked stream of samples starts. The tests of the ignored serial lines keep toggling those lines throughout a checked stream.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    localparam int SLICE_W    = 4;
    localparam int CELL_DEPTH = 32;

    typedef enum logic {
        CFG_HOLD  = 1'b0,
        CFG_SHIFT = 1'b1
    } cfg_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } cell_out_t;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int tree_levels(input int n);
        int lv;
        lv = 1;
        while ((1 << lv) < n) lv++;
        return lv;
    endfunction

endpackage

// File: rtl/rcm_cfg_cell.sv
module rcm_cfg_cell
    import rcm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic                din,
    input  logic [SLICE_W-1:0]  addr,
    output cell_out_t           rd
);

    logic [CELL_DEPTH-1:0] store;
    cfg_mode_e             mode;

    assign mode = shift_en ? CFG_SHIFT : CFG_HOLD;

    always_ff @(posedge clk) begin
        if (rst) begin
            store <= '0;
        end else if (mode == CFG_SHIFT) begin
            store <= {store[CELL_DEPTH-2:0], din};
        end
    end

    assign rd.lo = store[{1'b0, addr}];
    assign rd.hi = store[{1'b1, addr}];

endmodule

// File: rtl/rcm_slice_table.sv
module rcm_slice_table
    import rcm_pkg::*;
#(
    parameter int PP_W = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          shift_en,
    input  logic [ceil_div(PP_W,2)-1:0]   din,
    input  logic [SLICE_W-1:0]            addr,
    output logic [PP_W-1:0]               rd
);

    localparam int NCELL = ceil_div(PP_W, 2);

    cell_out_t [NCELL-1:0] cell_rd;

    for (genvar j = 0; j < NCELL; j++) begin : g_cell
        rcm_cfg_cell cell_i (
            .clk      (clk),
            .rst      (rst),
            .shift_en (shift_en),
            .din      (din[j]),
            .addr     (addr),
            .rd       (cell_rd[j])
        );
    end

    for (genvar b = 0; b < PP_W; b++) begin : g_bit
        if (b % 2 == 1) begin : g_hi
            assign rd[b] = cell_rd[b/2].hi;
        end else begin : g_lo
            assign rd[b] = cell_rd[b/2].lo;
        end
    end

endmodule

// File: rtl/rcm_add_tree.sv
module rcm_add_tree #(
    parameter int W     = 18,
    parameter int NLEAF = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NLEAF-1:0][W-1:0]   leaf,
    output logic [W-1:0]              root
);

    localparam int NNODE = NLEAF - 1;

    logic [W-1:0] node [NNODE];

    for (genvar i = 0; i < NNODE; i++) begin : g_node
        localparam int CL = 2 * i + 1;
        localparam int CR = 2 * i + 2;
        logic [W-1:0] opa;
        logic [W-1:0] opb;

        if (CL >= NNODE) begin : g_la
            assign opa = leaf[CL - NNODE];
        end else begin : g_na
            assign opa = node[CL];
        end

        if (CR >= NNODE) begin : g_lb
            assign opb = leaf[CR - NNODE];
        end else begin : g_nb
            assign opb = node[CR];
        end

        always_ff @(posedge clk) begin
            if (rst) node[i] <= '0;
            else     node[i] <= opa + opb;
        end
    end

    assign root = node[0];

endmodule

// File: rtl/reconf_const_mult.sv
module reconf_const_mult
    import rcm_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int COEF_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   cfg_en,
    input  logic [ceil_div(COEF_W+SLICE_W,2)-1:0]  cfg_lo_din,
    input  logic [ceil_div(COEF_W+SLICE_W,2)-1:0]  cfg_hi_din,
    input  logic [DATA_W-1:0]                      data_in,
    output logic [DATA_W+COEF_W-1:0]               product
);

    localparam int NSLICE = ceil_div(DATA_W, SLICE_W);
    localparam int XW     = NSLICE * SLICE_W;
    localparam int PP_W   = COEF_W + SLICE_W;
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int LEV    = tree_levels(NSLICE);
    localparam int NLEAF  = 1 << LEV;

    // stage 1: input register and sign extension
    logic signed [DATA_W-1:0] din_q;
    logic signed [XW-1:0]     x_ext;

    always_ff @(posedge clk) begin
        if (rst) din_q <= '0;
        else     din_q <= data_in;
    end

    assign x_ext = XW'(din_q);

    // slice tables, then stage 2: partial-product register
    logic [NSLICE-1:0][SLICE_W-1:0] slice_addr;
    logic [NSLICE-1:0][PP_W-1:0]    tab_rd;
    logic [NSLICE-1:0][PP_W-1:0]    pp_q;

    for (genvar l = 0; l < NSLICE; l++) begin : g_slice
        localparam bit IS_TOP = (l == NSLICE - 1);
        assign slice_addr[l] = x_ext[l*SLICE_W +: SLICE_W];

        rcm_slice_table #(.PP_W(PP_W)) tab_i (
            .clk      (clk),
            .rst      (rst),
            .shift_en (cfg_en),
            .din      (IS_TOP ? cfg_hi_din : cfg_lo_din),
            .addr     (slice_addr[l]),
            .rd       (tab_rd[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) pp_q <= '0;
        else     pp_q <= tab_rd;
    end

    // weighting and pipelined summation
    logic [NLEAF-1:0][PROD_W-1:0] leaf;

    for (genvar k = 0; k < NLEAF; k++) begin : g_leaf
        if (k < NSLICE) begin : g_used
            assign leaf[k] = PROD_W'($signed(pp_q[k])) << (SLICE_W * k);
        end else begin : g_pad
            assign leaf[k] = '0;
        end
    end

    rcm_add_tree #(.W(PROD_W), .NLEAF(NLEAF)) tree_i (
        .clk  (clk),
        .rst  (rst),
        .leaf (leaf),
        .root (product)
    );

endmodule

// File: rtl/rcm_chk.sv
module rcm_chk
    import rcm_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int COEF_W = 8,
    parameter int NSLICE = ceil_div(DATA_W, SLICE_W),
    parameter int PP_W   = COEF_W + SLICE_W,
    parameter int PROD_W = DATA_W + COEF_W,
    parameter int LEV    = tree_levels(NSLICE)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_en,
    input  logic [DATA_W-1:0]             data_in,
    input  logic [PROD_W-1:0]             product,
    input  logic [NSLICE-1:0][SLICE_W-1:0] slice_addr,
    input  logic [NSLICE-1:0][PP_W-1:0]   tab_rd,
    input  logic [NSLICE-1:0][PP_W-1:0]   pp_q
);

    localparam int LAT   = 2 + LEV;
    localparam int TOPLO = DATA_W - SLICE_W * (NSLICE - 1) - 1;

    logic [3:0]        warm_cnt;
    logic [7:0]        idle_cnt;
    logic [DATA_W-1:0] prev_din;
    logic [PROD_W-1:0] wsum;
    logic [SLICE_W-1-TOPLO:0] msb_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_cnt <= '0;
            idle_cnt <= '0;
        end else begin
            if (warm_cnt != 4'hF) warm_cnt <= warm_cnt + 4'd1;
            if (!cfg_en && data_in == prev_din) begin
                if (idle_cnt != 8'hFF) idle_cnt <= idle_cnt + 8'd1;
            end else begin
                idle_cnt <= '0;
            end
        end
        prev_din <= data_in;
    end

    always_comb begin
        wsum = '0;
        for (int l = 0; l < NSLICE; l++) begin
            wsum = wsum + (PROD_W'($signed(pp_q[l])) << (SLICE_W * l));
        end
    end

    assign msb_top = slice_addr[NSLICE-1][SLICE_W-1:TOPLO];

    AST_SIGN_PAD: assert property (@(posedge clk) disable iff (rst || warm_cnt == 4'd0)
        $past(data_in[DATA_W-1]) ? (msb_top == '1) : (msb_top == '0)); // R3

    AST_TREE_SUM: assert property (@(posedge clk) disable iff (rst || warm_cnt <= 4'(LEV))
        product == $past(wsum, LEV)); // R4

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt >= 8'(LAT + 1)) |-> $stable(product)); // R7

    for (genvar l = 1; l < NSLICE - 1; l++) begin : g_shared
        AST_LOWER_SHARED: assert property (@(posedge clk) disable iff (rst)
            (slice_addr[l] == slice_addr[0]) |-> (tab_rd[l] == tab_rd[0])); // R5
    end

endmodule

bind reconf_const_mult rcm_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_en     (cfg_en),
    .data_in    (data_in),
    .product    (product),
    .slice_addr (slice_addr),
    .tab_rd     (tab_rd),
    .pp_q       (pp_q)
);

// File: tb/reconf_const_mult_tb_top.sv
`timescale 1ns/1ps
module reconf_const_mult_tb_top;

    localparam int DATA_W = 10;
    localparam int COEF_W = 8;
    localparam int NSLICE = (DATA_W + 3) / 4;
    localparam int PP_W   = COEF_W + 4;
    localparam int NCELL  = (PP_W + 1) / 2;
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int LAT    = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_en;
    logic [NCELL-1:0]  cfg_lo_din;
    logic [NCELL-1:0]  cfg_hi_din;
    logic [DATA_W-1:0] data_in;
    logic [PROD_W-1:0] product;

    int checks = 0;
    int errors = 0;

    logic [PP_W-1:0]   lo_tab [16];
    logic [PP_W-1:0]   hi_tab [16];
    logic [DATA_W-1:0] stim   [256];

    always #2.5 clk = ~clk;

    reconf_const_mult #(.DATA_W(DATA_W), .COEF_W(COEF_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_en     (cfg_en),
        .cfg_lo_din (cfg_lo_din),
        .cfg_hi_din (cfg_hi_din),
        .data_in    (data_in),
        .product    (product)
    );

    task automatic check(input string tag, input logic [PROD_W-1:0] act, input logic [PROD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: product actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
        end
    endtask

    // R4 prediction from the bench tables
    function automatic logic [PROD_W-1:0] model(input logic [DATA_W-1:0] x);
        int xi;
        int acc;
        int a;
        int e;
        xi  = $signed(x);
        acc = 0;
        for (int l = 0; l < NSLICE; l++) begin
            a = (xi >>> (4 * l)) & 15;
            if (l == NSLICE - 1) e = $signed(hi_tab[a]);
            else                 e = $signed(lo_tab[a]);
            acc = acc + e * (1 << (4 * l));
        end
        return PROD_W'(acc);
    endfunction

    task automatic fill_products(input int c_lo, input int c_hi);
        for (int a = 0; a < 16; a++) begin
            lo_tab[a] = PP_W'(a * c_lo);
            hi_tab[a] = PP_W'(((a < 8) ? a : a - 16) * c_hi);
        end
    endtask

    task automatic fill_random();
        for (int a = 0; a < 16; a++) begin
            lo_tab[a] = PP_W'($urandom);
            hi_tab[a] = PP_W'($urandom);
        end
    endtask

    task automatic fill_zero();
        for (int a = 0; a < 16; a++) begin
            lo_tab[a] = '0;
            hi_tab[a] = '0;
        end
    endtask

    // R6 bit order; gap > 0 splits the load into two bursts
    task automatic load(input int gap);
        int bi;
        int en;
        for (int t = 0; t < 32; t++) begin
            if (t == 16) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    cfg_en     = 1'b0;
                    cfg_lo_din = NCELL'($urandom);
                    cfg_hi_din = NCELL'($urandom);
                end
            end
            @(negedge clk);
            cfg_en = 1'b1;
            en = (t < 16) ? 15 - t : 31 - t;
            for (int j = 0; j < NCELL; j++) begin
                bi = (t < 16) ? 2 * j + 1 : 2 * j;
                cfg_lo_din[j] = (bi < PP_W) ? lo_tab[en][bi] : 1'b0;
                cfg_hi_din[j] = (bi < PP_W) ? hi_tab[en][bi] : 1'b0;
            end
        end
        @(negedge clk);
        cfg_en     = 1'b0;
        cfg_lo_din = '0;
        cfg_hi_din = '0;
    endtask

    task automatic random_stim(input int n);
        for (int i = 0; i < n; i++) stim[i] = DATA_W'($urandom);
    endtask

    // drive n samples; each is checked LAT falling edges after it is driven
    task automatic play(input string tag, input int n, input int coef, input bit use_mult, input bit wiggle);
        logic [PROD_W-1:0] exp;
        int xi;
        for (int i = 0; i < n + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT) begin
                xi  = $signed(stim[i-LAT]);
                exp = use_mult ? PROD_W'(xi * coef) : model(stim[i-LAT]);
                check(tag, product, exp);
            end
            if (i < n) data_in = stim[i];
            if (wiggle) begin
                cfg_lo_din = NCELL'($urandom);
                cfg_hi_din = NCELL'($urandom);
            end
        end
        cfg_lo_din = '0;
        cfg_hi_din = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5120));
        rst        = 1'b1;
        cfg_en     = 1'b0;
        cfg_lo_din = '0;
        cfg_hi_din = '0;
        data_in    = '0;
        repeat (3) @(negedge clk);
        check("R1 reset state", product, '0);
        rst = 1'b0;

        // R1: cleared tables give zero for any input
        fill_zero();
        random_stim(20);
        play("R1 cleared tables", 20, 0, 1'b0, 1'b0);

        // R2: product tables, random stream
        fill_products(37, 37);
        load(0);
        random_stim(100);
        play("R2 c=37", 100, 37, 1'b1, 1'b0);

        // R8: extreme operands
        fill_products(-128, -128);
        load(0);
        stim[0] = 10'h200; stim[1] = 10'h1FF; stim[2] = 10'h3FF; stim[3] = 10'h000;
        stim[4] = 10'h001; stim[5] = 10'h3F8; stim[6] = 10'h007; stim[7] = 10'h3F7;
        stim[8] = 10'h008; stim[9] = 10'h100; stim[10] = 10'h300; stim[11] = 10'h200;
        play("R8 c=-128", 12, -128, 1'b1, 1'b0);
        fill_products(127, 127);
        load(0);
        stim[0] = 10'h200; stim[1] = 10'h1FF; stim[2] = 10'h3FF; stim[3] = 10'h200;
        play("R8 c=127", 4, 127, 1'b1, 1'b0);
        random_stim(40);
        play("R2 c=127", 40, 127, 1'b1, 1'b0);

        // R4: arbitrary table contents
        fill_random();
        load(0);
        random_stim(80);
        play("R4 arbitrary tables", 80, 0, 1'b0, 1'b0);

        // R3: sign padding selects the top-table entry
        stim[0] = 10'h200; stim[1] = 10'h3FF; stim[2] = 10'h1FF; stim[3] = 10'h100;
        stim[4] = 10'h2F0; stim[5] = 10'h00F; stim[6] = 10'h0F0; stim[7] = 10'h300;
        play("R3 sign extension", 8, 0, 1'b0, 1'b0);

        // R7: serial lines toggle with cfg_en low
        random_stim(40);
        play("R7 lines ignored", 40, 0, 1'b0, 1'b1);

        // R5: lower and top tables carry different constants
        fill_products(5, -3);
        load(0);
        random_stim(60);
        play("R5 separate top table", 60, 0, 1'b0, 1'b0);

        // R6: split load equals a continuous one
        fill_random();
        load(7);
        random_stim(40);
        play("R6 split load", 40, 0, 1'b0, 1'b0);
        fill_products(-77, -77);
        load(0);
        random_stim(40);
        play("R6 reload c=-77", 40, -77, 1'b1, 1'b0);

        // R1: reset in mid-run clears tables again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 after second reset", product, '0);
        fill_zero();
        random_stim(20);
        play("R1 tables cleared by reset", 20, 0, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule